// File: doc/BRIEF.md
# Address Window Decoder with Remap

This block maps each CPU-side address onto one of eight programmable windows. Every window is described by a base address, a size, a target identifier, an attribute byte and an enable. Windows that support translation also have a remap base. When an address falls inside an enabled window, the decoder reports a hit and returns the window number, the target identifier and the attribute. It also returns an output address. In that address, the bits above the window size are replaced with the remap base and the bits inside the window are kept.

The size of a window is given in 64 KB pages. The size field is a mask of contiguous ones that starts at bit 0. Each additional one doubles the window, so a mask of 0x00FF gives 16 MB and a mask of zero gives a single 64 KB page. Software that does not want translation programs the remap base equal to the base. Windows built without remap registers always pass the address through unchanged.

Software programs the windows through a single-cycle register port with combinational readback. Decode results appear one clock after the address is presented.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled and every register reads zero. A decode in this state reports a miss.
- R2: The register port is addressed by `cfg_addr`. Bits [4:2] select the window and bits [1:0] select the register: 0 control, 1 base, 2 remap-low, 3 remap-high. The control word holds the enable in bit 0, the target in [7:4], the attribute in [15:8] and the size mask in [31:16]. Control bits [3:1] read as zero. Every other implemented bit reads back the value last written.
- R3: An enabled window matches when the upper 16 address bits equal the base's upper 16 bits at every position where the size mask is zero. With a size mask of zero, exactly one 64 KB page matches.
- R4: A disabled window never produces a hit, whatever its base and size.
- R5: When more than one enabled window matches, the window with the lowest number is reported.
- R6: On a miss, `out_hit`, `out_win`, `out_tgt` and `out_attr` are zero and `out_addr` equals the input address.
- R7: On a hit in a window that supports remap, the upper 16 bits of `out_addr` take remap-low bits where the size mask is zero and address bits where it is one.
- R8: Windows 4 to 7 (parameter `REMAP_MASK`, default 0x0F) have no remap registers. A hit there passes the address through unchanged. Their remap registers read zero and ignore writes.
- R9: Decode has one cycle of latency. `out_valid` equals `in_valid` from the previous cycle.
- R10: A register write takes effect for addresses presented from the next cycle on. An address presented in the same cycle as the write is decoded with the old settings.
- R11: The lower 16 bits of `out_addr` always equal the lower 16 bits of the address that was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Window number [4:2] and register select [1:0] |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational readback of the selected register |
| in_valid | input | 1 | Address strobe |
| in_addr | input | 32 | Address to decode |
| out_valid | output | 1 | Decode result valid |
| out_hit | output | 1 | Address fell inside an enabled window |
| out_win | output | 3 | Number of the matching window |
| out_tgt | output | 4 | Target identifier of the matching window |
| out_attr | output | 8 | Attribute of the matching window |
| out_addr | output | 32 | Translated address |

## Verification
The assertions check several rules on every cycle. `out_valid` follows the previous strobe, and a hit is only reported with a valid result. A miss carries zero target, attribute and window fields. The low 16 address bits always pass through. A hit names a window that was enabled, and a hit in a window without remap leaves the address untouched. Other behaviour needs the bench's scenarios, which compare results against a reference model. This covers the match rule at window edges, the 64 KB minimum window, lowest-number priority between overlapping windows, remap arithmetic, register readback, and the write that coincides with a decode.

// File: rtl/awd_pkg.sv
package awd_pkg;

    // register select codes within one window
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_BASE = 2'd1;
    localparam logic [1:0] SEL_RLO  = 2'd2;
    localparam logic [1:0] SEL_RHI  = 2'd3;

    // control word field positions (size occupies the top bits)
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_TGT_LSB  = 4;
    localparam int CTRL_ATTR_LSB = 8;

endpackage

// File: rtl/awd_win_regs.sv
module awd_win_regs
    import awd_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int AW   = 32,
    parameter int PW   = 16,
    parameter int TW   = 4,
    parameter int ATW  = 8,
    parameter logic [NWIN-1:0] REMAP_MASK = 8'h0F,
    localparam int SW  = AW - PW,
    localparam int IW  = $clog2(NWIN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IW-1:0]            win_sel,
    input  logic [1:0]               reg_sel,
    input  logic [AW-1:0]            wr_data,
    output logic [AW-1:0]            rd_data,
    output logic [NWIN-1:0]          en_o,
    output logic [NWIN-1:0][TW-1:0]  tgt_o,
    output logic [NWIN-1:0][ATW-1:0] attr_o,
    output logic [NWIN-1:0][SW-1:0]  size_o,
    output logic [NWIN-1:0][SW-1:0]  base_up_o,
    output logic [NWIN-1:0][SW-1:0]  rlo_up_o
);

    typedef struct packed {
        logic           en;
        logic [TW-1:0]  tgt;
        logic [ATW-1:0] attr;
        logic [SW-1:0]  size;
        logic [AW-1:0]  base;
        logic [AW-1:0]  rlo;
        logic [AW-1:0]  rhi;
    } win_cfg_t;

    logic [AW-1:0] rd_words [NWIN][4];

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        win_cfg_t      cfg_d, cfg_q;
        logic [AW-1:0] ctrl_word;

        always_comb begin
            cfg_d = cfg_q;
            if (wr_en && win_sel == IW'(g)) begin
                case (reg_sel)
                    SEL_CTRL: begin
                        cfg_d.en   = wr_data[CTRL_EN_BIT];
                        cfg_d.tgt  = wr_data[CTRL_TGT_LSB +: TW];
                        cfg_d.attr = wr_data[CTRL_ATTR_LSB +: ATW];
                        cfg_d.size = wr_data[AW-1 -: SW];
                    end
                    SEL_BASE: cfg_d.base = wr_data;
                    SEL_RLO:  cfg_d.rlo  = wr_data;
                    default:  cfg_d.rhi  = wr_data;
                endcase
            end
            if (!REMAP_MASK[g]) begin
                cfg_d.rlo = '0;
                cfg_d.rhi = '0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cfg_q <= '0;
            else        cfg_q <= cfg_d;
        end

        always_comb begin
            ctrl_word                         = '0;
            ctrl_word[CTRL_EN_BIT]            = cfg_q.en;
            ctrl_word[CTRL_TGT_LSB +: TW]     = cfg_q.tgt;
            ctrl_word[CTRL_ATTR_LSB +: ATW]   = cfg_q.attr;
            ctrl_word[AW-1 -: SW]             = cfg_q.size;
        end

        assign rd_words[g][0] = ctrl_word;
        assign rd_words[g][1] = cfg_q.base;
        assign rd_words[g][2] = cfg_q.rlo;
        assign rd_words[g][3] = cfg_q.rhi;

        assign en_o[g]      = cfg_q.en;
        assign tgt_o[g]     = cfg_q.tgt;
        assign attr_o[g]    = cfg_q.attr;
        assign size_o[g]    = cfg_q.size;
        assign base_up_o[g] = cfg_q.base[AW-1 -: SW];
        assign rlo_up_o[g]  = cfg_q.rlo[AW-1 -: SW];
    end

    assign rd_data = rd_words[win_sel][reg_sel];

endmodule

// File: rtl/awd_win_match.sv
module awd_win_match #(
    parameter int AW        = 32,
    parameter int PW        = 16,
    parameter bit HAS_REMAP = 1'b1,
    localparam int SW       = AW - PW
) (
    input  logic          en,
    input  logic [SW-1:0] size,
    input  logic [SW-1:0] base_up,
    input  logic [SW-1:0] rlo_up,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [AW-1:0] xaddr
);

    logic [SW-1:0] addr_up;
    logic [SW-1:0] fixed_mask;

    assign addr_up    = addr[AW-1 -: SW];
    assign fixed_mask = ~size;

    always_comb begin
        hit = en && ((addr_up & fixed_mask) == (base_up & fixed_mask));
    end

    if (HAS_REMAP) begin : g_remap
        assign xaddr = {(rlo_up & fixed_mask) | (addr_up & size), addr[PW-1:0]};
    end else begin : g_pass
        logic [SW-1:0] unused_rlo;
        assign unused_rlo = rlo_up;
        assign xaddr      = addr;
    end

endmodule

// File: rtl/awd_pick.sv
module awd_pick #(
    parameter int NWIN = 8,
    parameter int AW   = 32,
    parameter int TW   = 4,
    parameter int ATW  = 8,
    localparam int IW  = $clog2(NWIN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [AW-1:0]            in_addr,
    input  logic [NWIN-1:0]          hit_vec,
    input  logic [NWIN-1:0][AW-1:0]  xaddr,
    input  logic [NWIN-1:0][TW-1:0]  tgt,
    input  logic [NWIN-1:0][ATW-1:0] attr,
    output logic                     out_valid,
    output logic                     out_hit,
    output logic [IW-1:0]            out_win,
    output logic [TW-1:0]            out_tgt,
    output logic [ATW-1:0]           out_attr,
    output logic [AW-1:0]            out_addr
);

    typedef struct packed {
        logic           valid;
        logic           hit;
        logic [IW-1:0]  win;
        logic [TW-1:0]  tgt;
        logic [ATW-1:0] attr;
        logic [AW-1:0]  addr;
    } res_t;

    res_t res_d, res_q;

    // scan from the top so the lowest-numbered match is written last
    always_comb begin
        res_d       = '0;
        res_d.valid = in_valid;
        res_d.addr  = in_addr;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (in_valid && hit_vec[i]) begin
                res_d.hit  = 1'b1;
                res_d.win  = IW'(i);
                res_d.tgt  = tgt[i];
                res_d.attr = attr[i];
                res_d.addr = xaddr[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_hit   = res_q.hit;
    assign out_win   = res_q.win;
    assign out_tgt   = res_q.tgt;
    assign out_attr  = res_q.attr;
    assign out_addr  = res_q.addr;

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
    parameter int NWIN   = 8,
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 16,
    parameter int TGT_W  = 4,
    parameter int ATTR_W = 8,
    parameter logic [NWIN-1:0] REMAP_MASK = 8'h0F,
    localparam int IW    = $clog2(NWIN),
    localparam int SW    = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [IW+1:0]     cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic [IW-1:0]     out_win,
    output logic [TGT_W-1:0]  out_tgt,
    output logic [ATTR_W-1:0] out_attr,
    output logic [ADDR_W-1:0] out_addr
);

    logic [NWIN-1:0]             win_en;
    logic [NWIN-1:0][TGT_W-1:0]  win_tgt;
    logic [NWIN-1:0][ATTR_W-1:0] win_attr;
    logic [NWIN-1:0][SW-1:0]     win_size;
    logic [NWIN-1:0][SW-1:0]     win_base;
    logic [NWIN-1:0][SW-1:0]     win_rlo;
    logic [NWIN-1:0]             win_hit;
    logic [NWIN-1:0][ADDR_W-1:0] win_xaddr;

    awd_win_regs #(
        .NWIN(NWIN), .AW(ADDR_W), .PW(PAGE_W), .TW(TGT_W), .ATW(ATTR_W),
        .REMAP_MASK(REMAP_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .win_sel   (cfg_addr[IW+1:2]),
        .reg_sel   (cfg_addr[1:0]),
        .wr_data   (cfg_wdata),
        .rd_data   (cfg_rdata),
        .en_o      (win_en),
        .tgt_o     (win_tgt),
        .attr_o    (win_attr),
        .size_o    (win_size),
        .base_up_o (win_base),
        .rlo_up_o  (win_rlo)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_match
        awd_win_match #(
            .AW(ADDR_W), .PW(PAGE_W), .HAS_REMAP(REMAP_MASK[g])
        ) u_match (
            .en      (win_en[g]),
            .size    (win_size[g]),
            .base_up (win_base[g]),
            .rlo_up  (win_rlo[g]),
            .addr    (in_addr),
            .hit     (win_hit[g]),
            .xaddr   (win_xaddr[g])
        );
    end

    awd_pick #(
        .NWIN(NWIN), .AW(ADDR_W), .TW(TGT_W), .ATW(ATTR_W)
    ) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_addr   (in_addr),
        .hit_vec   (win_hit),
        .xaddr     (win_xaddr),
        .tgt       (win_tgt),
        .attr      (win_attr),
        .out_valid (out_valid),
        .out_hit   (out_hit),
        .out_win   (out_win),
        .out_tgt   (out_tgt),
        .out_attr  (out_attr),
        .out_addr  (out_addr)
    );

endmodule

// File: rtl/awd_checks.sv
module awd_checks #(
    parameter int NWIN   = 8,
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 16,
    parameter int TGT_W  = 4,
    parameter int ATTR_W = 8,
    parameter logic [NWIN-1:0] REMAP_MASK = 8'h0F,
    localparam int IW    = $clog2(NWIN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic              out_hit,
    input logic [IW-1:0]     out_win,
    input logic [TGT_W-1:0]  out_tgt,
    input logic [ATTR_W-1:0] out_attr,
    input logic [ADDR_W-1:0] out_addr,
    input logic [NWIN-1:0]   win_en
);

    logic [NWIN-1:0] win_onehot;
    assign win_onehot = NWIN'(1) << out_win;

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R1
    hit_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> out_valid);

    // R6
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_tgt == '0 && out_attr == '0 && out_win == '0));

    // R11
    low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_addr[PAGE_W-1:0] == $past(in_addr[PAGE_W-1:0]));

    // R4
    hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_hit || (win_onehot & $past(win_en)) != '0));

    // R8
    noremap_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_hit || REMAP_MASK[out_win] || out_addr == $past(in_addr)));

endmodule

bind addr_window_decoder awd_checks #(
    .NWIN(NWIN), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TGT_W(TGT_W),
    .ATTR_W(ATTR_W), .REMAP_MASK(REMAP_MASK)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .out_valid (out_valid),
    .out_hit   (out_hit),
    .out_win   (out_win),
    .out_tgt   (out_tgt),
    .out_attr  (out_attr),
    .out_addr  (out_addr),
    .win_en    (win_en)
);

// File: tb/sim_addr_window_decoder.sv
module sim_addr_window_decoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid, out_hit;
    logic [2:0]  out_win;
    logic [3:0]  out_tgt;
    logic [7:0]  out_attr;
    logic [31:0] out_addr;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_ctrl [8];
    logic [31:0] m_base [8];
    logic [31:0] m_rlo  [8];
    logic [31:0] m_rhi  [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_window_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
        .in_addr(in_addr), .out_valid(out_valid), .out_hit(out_hit),
        .out_win(out_win), .out_tgt(out_tgt), .out_attr(out_attr),
        .out_addr(out_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic void model_wr(input int w, input int sel, input logic [31:0] d);
        case (sel)
            0: m_ctrl[w] = d & 32'hFFFF_FFF1;
            1: m_base[w] = d;
            2: if (w < 4) m_rlo[w] = d;
            default: if (w < 4) m_rhi[w] = d;
        endcase
    endfunction

    function automatic logic [63:0] predict(input logic [31:0] a);
        logic        hit = 1'b0;
        logic [2:0]  win = '0;
        logic [3:0]  tgt = '0;
        logic [7:0]  attr = '0;
        logic [31:0] oa = a;
        for (int w = 0; w < 8; w++) begin
            logic [15:0] sz = m_ctrl[w][31:16];
            if (!hit && m_ctrl[w][0] && (((a[31:16] ^ m_base[w][31:16]) & ~sz) == 16'h0)) begin
                hit  = 1'b1;
                win  = 3'(w);
                tgt  = m_ctrl[w][7:4];
                attr = m_ctrl[w][15:8];
                if (w < 4) oa = {(m_rlo[w][31:16] & ~sz) | (a[31:16] & sz), a[15:0]};
            end
        end
        return {15'b0, 1'b1, hit, win, tgt, attr, oa};
    endfunction

    function automatic logic [63:0] observed();
        return {15'b0, out_valid, out_hit, out_win, out_tgt, out_attr, out_addr};
    endfunction

    // called just after a falling edge
    task automatic wr(input int w, input int sel, input logic [31:0] d);
        cfg_addr  = {3'(w), 2'(sel)};
        cfg_wdata = d;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
        model_wr(w, sel, d);
    endtask

    task automatic rd(input int w, input int sel, input logic [31:0] exp, input string tag);
        cfg_addr = {3'(w), 2'(sel)};
        #1;
        chk(cfg_rdata == exp, tag, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic dec(input logic [31:0] a, input string tag);
        logic [63:0] exp = predict(a);
        in_valid = 1'b1;
        in_addr  = a;
        @(negedge clk);
        chk(observed() == exp, tag, observed(), exp);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        void'($urandom(32'd20417));
        for (int w = 0; w < 8; w++) begin
            m_ctrl[w] = '0; m_base[w] = '0; m_rlo[w] = '0; m_rhi[w] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: all registers zero, decode misses
        for (int w = 0; w < 8; w++)
            for (int s = 0; s < 4; s++)
                rd(w, s, 32'h0, "R1 reset readback");
        dec(32'h1234_5678, "R1 miss after reset");
        dec(32'h0000_0000, "R6 miss zero fields");

        // R2: readback with reserved control bits cleared
        wr(0, 0, 32'hFFFF_FFFF);
        rd(0, 0, 32'hFFFF_FFF1, "R2 ctrl readback");
        wr(0, 0, 32'h0);
        wr(2, 1, 32'hDEAD_BEEF);
        rd(2, 1, 32'hDEAD_BEEF, "R2 base readback");
        wr(3, 3, 32'h0BAD_F00D);
        rd(3, 3, 32'h0BAD_F00D, "R2 remap-high readback");
        // R8: remap registers absent on window 5
        wr(5, 2, 32'h7777_0000);
        rd(5, 2, 32'h0, "R8 remap-low ignored");
        wr(6, 3, 32'h1111_2222);
        rd(6, 3, 32'h0, "R8 remap-high ignored");

        // window 0: 16 MB at 0x1000_0000, remapped to 0x4000_0000
        wr(0, 1, 32'h1000_0000);
        wr(0, 2, 32'h4000_0000);
        wr(0, 0, {16'h00FF, 8'hA5, 4'h3, 3'b0, 1'b1});
        dec(32'h10AB_CDEF, "R7 remap inside window");
        dec(32'h10FF_FFFF, "R3 last byte of window");
        dec(32'h1100_0000, "R3 first byte past window");
        dec(32'h0FFF_FFFF, "R3 byte below window");

        // R3: size zero gives one 64 KB page, remap equal to base passes
        wr(1, 1, 32'h2000_0000);
        wr(1, 2, 32'h2000_0000);
        wr(1, 0, {16'h0000, 8'h11, 4'h9, 3'b0, 1'b1});
        dec(32'h2000_1234, "R3 size-zero page hit");
        dec(32'h2001_0000, "R3 size-zero page miss");

        // R5: overlapping 256 MB window 3
        wr(3, 1, 32'h1000_0000);
        wr(3, 2, 32'h8000_0000);
        wr(3, 0, {16'h0FFF, 8'h5A, 4'h7, 3'b0, 1'b1});
        dec(32'h10AB_CDEF, "R5 lowest window wins");
        dec(32'h1234_0000, "R5 only upper window");

        // R8: window 5 without remap
        wr(5, 1, 32'h3000_0000);
        wr(5, 0, {16'h0003, 8'hC3, 4'hE, 3'b0, 1'b1});
        dec(32'h3002_5555, "R8 pass-through hit");

        // R4: disable window 0
        wr(0, 0, {16'h00FF, 8'hA5, 4'h3, 3'b0, 1'b0});
        dec(32'h10AB_CDEF, "R4 disabled window skipped");
        wr(3, 0, {16'h0FFF, 8'h5A, 4'h7, 3'b0, 1'b0});
        dec(32'h10AB_CDEF, "R4 all covering windows disabled");

        // R9: idle cycle drops out_valid
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 idle after decode", 64'(out_valid), 64'd0);

        // R10: write and decode in the same cycle
        wr(7, 1, 32'h5000_0000);
        begin
            logic [63:0] exp_old = predict(32'h5000_0042);
            cfg_addr  = {3'd7, 2'd0};
            cfg_wdata = {16'h0000, 8'h77, 4'h2, 3'b0, 1'b1};
            cfg_wr    = 1'b1;
            in_valid  = 1'b1;
            in_addr   = 32'h5000_0042;
            @(negedge clk);
            cfg_wr   = 1'b0;
            in_valid = 1'b0;
            chk(observed() == exp_old, "R10 same-cycle uses old", observed(), exp_old);
            model_wr(7, 0, {16'h0000, 8'h77, 4'h2, 3'b0, 1'b1});
        end
        dec(32'h5000_0042, "R10 next cycle uses new");

        // random configurations and addresses
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(0, 3) == 0) begin
                int          w  = $urandom_range(0, 7);
                int          k  = $urandom_range(0, 16);
                logic [15:0] sz = 16'((32'd1 << k) - 1);
                logic        en = ($urandom_range(0, 4) != 0);
                wr(w, 1, $urandom());
                wr(w, 2, $urandom());
                wr(w, 0, {sz, 8'($urandom()), 4'($urandom()), 3'b0, en});
            end
            begin
                logic [31:0] a;
                if ($urandom_range(0, 1) == 0) begin
                    int          v  = $urandom_range(0, 7);
                    logic [15:0] sz = m_ctrl[v][31:16];
                    a = {(m_base[v][31:16] & ~sz) | (16'($urandom()) & sz), 16'($urandom())};
                end else begin
                    a = $urandom();
                end
                dec(a, "R3 R5 R7 random decode");
            end
        end

        report();
    end

endmodule